// File: doc/BRIEF.md
# Width-Down Read Unpacker with Byte-Order Swap

This block sits on the read side of a 36-bit FIFO and feeds an output port that can be set to full long words (36 bits), words (18 bits) or bytes (9 bits). The FIFO is always read one whole long word at a time. When a new word is taken, the block first rearranges its four 9-bit lanes according to a swap mode. It then sends the first piece to the output register and keeps the whole word in a staging register, so that later reads of the same size return the remaining pieces in turn.

The size and endian inputs are registered, and a read is carried out under the registered values. The swap mode only matters on the read that takes a new word. A read made under a size or endian setting different from the one the staged word was fetched under drops whatever is still staged and takes a fresh word. The FIFO is expected to present its head word on `fifo_word`. The combinational `pop` output tells it to advance on the same clock edge.

Top module: `bm_read_unpacker`

## Requirements
- R1: While `rst` is high, `dout` is all zeros and any staged data is dropped, so the first read after reset asserts `pop`.
- R2: `size_sel` and `big_end` are registered on every rising edge, and a read at edge k uses the values that were present at edge k-1. A size change made in the same cycle as a read does not affect that read.
- R3: With size 00 or 11 (long word), every read asserts `pop` and loads the whole swapped word into `dout`.
- R4: With size 01 (word), a read that fetches a word outputs one 18-bit half in `dout[17:0]`, and the next read outputs the other half without `pop`. `dout[35:18]` is zero.
- R5: With size 10 (byte), a fetch plus three further reads output the four 9-bit lanes one by one in `dout[8:0]`, with `pop` only on the fetch. `dout[35:9]` is zero.
- R6: With `big_end`=1 the most significant piece (`[35:27]` for bytes, `[35:18]` for words) is output first. With `big_end`=0 the least significant piece is output first.
- R7: Lanes are L3=`[35:27]` down to L0=`[8:0]`. The swap encodings, listed from L3 to L0, are: 00 gives L3 L2 L1 L0; 01 gives L0 L1 L2 L3; 10 gives L1 L0 L3 L2; 11 gives L2 L3 L0 L1. Bits inside a lane keep their order.
- R8: `swap_sel` is used only on a read that asserts `pop`. Later pieces of the same word follow the mode chosen on that read, whatever `swap_sel` does afterwards.
- R9: A read whose registered size or endian setting differs from the one the staged word was fetched under asserts `pop` and starts a fresh word. The unread staged pieces are lost.
- R10: `pop` is high only while `rd_en` is high. Without a read, `dout` keeps its value.
- R11: The read after the last piece of a word asserts `pop` and fetches a new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| fifo_word | input | 36 | Head word presented by the FIFO |
| rd_en | input | 1 | Read strobe for the output port |
| size_sel | input | 2 | Port size: 00/11 long word, 01 word, 10 byte |
| big_end | input | 1 | 1: most significant piece first, 0: least significant first |
| swap_sel | input | 2 | Lane order mode applied when a word is fetched |
| dout | output | 36 | Registered output data; unused lanes are zero |
| pop | output | 1 | Combinational request to advance the FIFO this edge |

## Verification
Two functions can fall in the same cycle: a change of the port setting and a read that drains staged pieces. The bench provokes this by changing `size_sel` in the very cycle of a byte-mode read. That read must still return the next byte without `pop`, and the read after it must fetch a fresh word in word mode, with the remaining bytes discarded. A second case changes the swap inputs between the pieces of one word. The later pieces must keep the order chosen when the word was fetched.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

    localparam int LANES = 4;

    typedef enum logic [1:0] {
        SZ_LONG     = 2'b00,
        SZ_WORD     = 2'b01,
        SZ_BYTE     = 2'b10,
        SZ_LONG_ALT = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        SW_NONE   = 2'b00,
        SW_REV    = 2'b01,
        SW_HALVES = 2'b10,
        SW_INHALF = 2'b11
    } swap_e;

    typedef struct packed {
        size_e size;
        logic  big;
    } cfg_t;

    // pieces per long word minus one
    function automatic logic [1:0] last_piece(size_e sz);
        case (sz)
            SZ_WORD: last_piece = 2'd1;
            SZ_BYTE: last_piece = 2'd3;
            default: last_piece = 2'd0;
        endcase
    endfunction

    // input lane feeding output lane i of the swapped word
    function automatic logic [1:0] swap_src(swap_e m, logic [1:0] i);
        case (m)
            SW_REV:    swap_src = ~i;
            SW_HALVES: swap_src = i ^ 2'b10;
            SW_INHALF: swap_src = i ^ 2'b01;
            default:   swap_src = i;
        endcase
    endfunction

    // {used, source lane} for output lane j of piece number idx
    function automatic logic [2:0] piece_src(size_e sz, logic big,
                                             logic [1:0] idx, logic [1:0] j);
        logic k;
        case (sz)
            SZ_WORD: begin
                k = big ? ~idx[0] : idx[0];
                piece_src = {~j[1], k, j[0]};
            end
            SZ_BYTE: begin
                piece_src = {(j == 2'd0), (big ? ~idx : idx)};
            end
            default: piece_src = {1'b1, j};
        endcase
    endfunction

endpackage

// File: rtl/bmu_swap.sv
module bmu_swap
    import bmu_pkg::*;
#(
    parameter int LANE_W = 9,
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic [WORD_W-1:0] word_in,
    input  swap_e             mode,
    output logic [WORD_W-1:0] word_out
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [1:0] src;
        always_comb begin
            src = swap_src(mode, 2'(i));
            word_out[i*LANE_W +: LANE_W] = word_in[src*LANE_W +: LANE_W];
        end
    end

endmodule

// File: rtl/bmu_piece_sel.sv
module bmu_piece_sel
    import bmu_pkg::*;
#(
    parameter int LANE_W = 9,
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic [WORD_W-1:0] word_in,
    input  cfg_t              cfg,
    input  logic [1:0]        idx,
    output logic [WORD_W-1:0] piece_out
);

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [2:0] sel;
        always_comb begin
            sel = piece_src(cfg.size, cfg.big, idx, 2'(j));
            piece_out[j*LANE_W +: LANE_W] =
                sel[2] ? word_in[sel[1:0]*LANE_W +: LANE_W] : '0;
        end
    end

endmodule

// File: rtl/bmu_seq.sv
module bmu_seq
    import bmu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rd_en,
    input  cfg_t       cfg_q,
    output logic       fetch,
    output logic [1:0] sel_idx,
    output cfg_t       cur_cfg,
    output logic [1:0] left
);

    logic [1:0] nxt_idx;
    logic       need_new;

    always_comb begin
        need_new = (left == 2'd0) || (cfg_q != cur_cfg);
        fetch    = rd_en && need_new;
        sel_idx  = need_new ? 2'd0 : nxt_idx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_cfg <= '{size: SZ_LONG, big: 1'b1};
            left    <= 2'd0;
            nxt_idx <= 2'd0;
        end else if (rd_en) begin
            if (need_new) begin
                cur_cfg <= cfg_q;
                left    <= last_piece(cfg_q.size);
                nxt_idx <= 2'd1;
            end else begin
                left    <= left - 2'd1;
                nxt_idx <= nxt_idx + 2'd1;
            end
        end
    end

endmodule

// File: rtl/bm_read_unpacker.sv
module bm_read_unpacker
    import bmu_pkg::*;
#(
    parameter int LANE_W = 9,
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] fifo_word,
    input  logic              rd_en,
    input  logic [1:0]        size_sel,
    input  logic              big_end,
    input  logic [1:0]        swap_sel,
    output logic [WORD_W-1:0] dout,
    output logic              pop
);

    cfg_t              cfg_q;
    cfg_t              cur_cfg;
    logic [1:0]        sel_idx;
    logic [1:0]        left;
    logic [WORD_W-1:0] swapped;
    logic [WORD_W-1:0] stage;
    logic [WORD_W-1:0] src_word;
    logic [WORD_W-1:0] piece;

    // port setting registered; applies from the following edge
    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '{size: SZ_LONG, big: 1'b1};
        else     cfg_q <= '{size: size_e'(size_sel), big: big_end};
    end

    bmu_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .cfg_q   (cfg_q),
        .fetch   (pop),
        .sel_idx (sel_idx),
        .cur_cfg (cur_cfg),
        .left    (left)
    );

    bmu_swap #(.LANE_W(LANE_W)) u_swap (
        .word_in  (fifo_word),
        .mode     (swap_e'(swap_sel)),
        .word_out (swapped)
    );

    // the swapped word is staged, so the swap mode is fixed per word
    assign src_word = pop ? swapped : stage;

    bmu_piece_sel #(.LANE_W(LANE_W)) u_sel (
        .word_in   (src_word),
        .cfg       (pop ? cfg_q : cur_cfg),
        .idx       (sel_idx),
        .piece_out (piece)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= '0;
            dout  <= '0;
        end else if (rd_en) begin
            if (pop) stage <= swapped;
            dout <= piece;
        end
    end

endmodule

// File: rtl/bm_read_unpacker_chk.sv
module bm_read_unpacker_chk
    import bmu_pkg::*;
#(
    parameter int LANE_W = 9,
    localparam int WORD_W = LANES * LANE_W
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_en,
    input logic              pop,
    input logic [1:0]        size_sel,
    input logic              big_end,
    input logic [WORD_W-1:0] dout,
    input cfg_t              cfg_q,
    input cfg_t              cur_cfg,
    input logic [1:0]        left
);

    assert_pop_needs_read_R10: assert property (@(posedge clk) disable iff (rst)
        pop |-> rd_en);

    assert_idle_holds_R10: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(dout));

    assert_cfg_latency_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cfg_q == {$past(size_sel), $past(big_end)}));

    assert_cfg_change_pops_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && cfg_q != cur_cfg) |-> pop);

    assert_drained_pops_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_en && left == 2'd0) |-> pop);

    assert_long_pops_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (cfg_q.size == SZ_LONG || cfg_q.size == SZ_LONG_ALT)) |-> pop);

    assert_byte_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !pop && cur_cfg.size == SZ_BYTE) |=> (dout[WORD_W-1:LANE_W] == '0));

endmodule

bind bm_read_unpacker bm_read_unpacker_chk #(.LANE_W(LANE_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .pop      (pop),
    .size_sel (size_sel),
    .big_end  (big_end),
    .dout     (dout),
    .cfg_q    (cfg_q),
    .cur_cfg  (cur_cfg),
    .left     (left)
);

// File: tb/bm_read_unpacker_test.sv
module bm_read_unpacker_test;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [35:0] fifo_word = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  size_sel = 2'b00;
    logic        big_end = 1'b1;
    logic [1:0]  swap_sel = 2'b00;
    logic [35:0] dout;
    logic        pop;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    bm_read_unpacker uut (
        .clk       (clk),
        .rst       (rst),
        .fifo_word (fifo_word),
        .rd_en     (rd_en),
        .size_sel  (size_sel),
        .big_end   (big_end),
        .swap_sel  (swap_sel),
        .dout      (dout),
        .pop       (pop)
    );

    localparam logic [35:0] WA = {9'h1A3, 9'h0B2, 9'h1C1, 9'h0D0};
    localparam logic [35:0] WB = {9'h111, 9'h022, 9'h133, 9'h044};

    typedef struct packed {
        logic [1:0]  sw;
        logic [35:0] din;
        logic [35:0] exp;
    } vec_t;

    // long-word mode vectors (R3, R7)
    localparam vec_t VT [8] = '{
        '{2'd0, WA, {9'h1A3, 9'h0B2, 9'h1C1, 9'h0D0}},
        '{2'd1, WA, {9'h0D0, 9'h1C1, 9'h0B2, 9'h1A3}},
        '{2'd2, WA, {9'h1C1, 9'h0D0, 9'h1A3, 9'h0B2}},
        '{2'd3, WA, {9'h0B2, 9'h1A3, 9'h0D0, 9'h1C1}},
        '{2'd0, WB, {9'h111, 9'h022, 9'h133, 9'h044}},
        '{2'd1, WB, {9'h044, 9'h133, 9'h022, 9'h111}},
        '{2'd2, WB, {9'h133, 9'h044, 9'h111, 9'h022}},
        '{2'd3, WB, {9'h022, 9'h111, 9'h044, 9'h133}}
    };

    task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one read: pop checked before the edge, dout after it
    task automatic rd(input logic exp_pop, input logic [35:0] exp_d, input string tag);
        rd_en = 1'b1;
        #1;
        check({tag, " pop"}, {35'b0, pop}, {35'b0, exp_pop});
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        check({tag, " dout"}, dout, exp_d);
    endtask

    task automatic set_cfg(input logic [1:0] sz, input logic be);
        size_sel = sz;
        big_end  = be;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 50000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        check("R1 reset dout", dout, '0);
        rst = 1'b0;

        // R3 R7: table walk in long-word mode
        set_cfg(2'b00, 1'b1);
        foreach (VT[i]) begin
            swap_sel  = VT[i].sw;
            fifo_word = VT[i].din;
            rd(1'b1, VT[i].exp, "R3 R7 long");
        end
        // size 11 also long
        set_cfg(2'b11, 1'b0);
        swap_sel = 2'd0; fifo_word = WB;
        rd(1'b1, WB, "R3 long alt");

        // R4 R6 R11: word mode, big-endian
        set_cfg(2'b01, 1'b1);
        fifo_word = WA;
        rd(1'b1, {18'b0, 9'h1A3, 9'h0B2}, "R4 R6 word first");
        fifo_word = WB;
        rd(1'b0, {18'b0, 9'h1C1, 9'h0D0}, "R4 word second");
        rd(1'b1, {18'b0, 9'h111, 9'h022}, "R11 word refetch");

        // R10: idle cycles hold output
        @(negedge clk);
        check("R10 idle pop", {35'b0, pop}, '0);
        @(negedge clk);
        check("R10 idle hold", dout, {18'b0, 9'h111, 9'h022});

        // R9 R6: endian change mid-word drops staged half
        set_cfg(2'b01, 1'b0);
        fifo_word = WA;
        rd(1'b1, {18'b0, 9'h1C1, 9'h0D0}, "R9 R6 endian change");
        rd(1'b0, {18'b0, 9'h1A3, 9'h0B2}, "R6 word little second");

        // R5 R6 R7: byte mode little-endian with full reversal
        set_cfg(2'b10, 1'b0);
        swap_sel = 2'd1; fifo_word = WA;
        rd(1'b1, {27'b0, 9'h1A3}, "R5 R7 byte le 0");
        rd(1'b0, {27'b0, 9'h0B2}, "R5 byte le 1");
        rd(1'b0, {27'b0, 9'h1C1}, "R5 byte le 2");
        rd(1'b0, {27'b0, 9'h0D0}, "R5 byte le 3");

        // R8: swap fixed at fetch
        set_cfg(2'b10, 1'b1);
        swap_sel = 2'd2; fifo_word = WA;
        rd(1'b1, {27'b0, 9'h1C1}, "R8 byte fetch");
        swap_sel = 2'd1; fifo_word = WB;
        rd(1'b0, {27'b0, 9'h0D0}, "R8 held swap 1");
        rd(1'b0, {27'b0, 9'h1A3}, "R8 held swap 2");
        rd(1'b0, {27'b0, 9'h0B2}, "R8 held swap 3");

        // R2 R9: size change in the same cycle as a read
        swap_sel = 2'd0;
        rd(1'b1, {27'b0, 9'h111}, "R11 byte refetch");
        size_sel = 2'b01;
        rd(1'b0, {27'b0, 9'h022}, "R2 old size used");
        fifo_word = WA;
        rd(1'b1, {18'b0, 9'h1A3, 9'h0B2}, "R9 new size fetch");

        // R1: reset mid-word drops staged data
        set_cfg(2'b10, 1'b1);
        fifo_word = WB;
        rd(1'b1, {27'b0, 9'h111}, "R5 byte before reset");
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 reset mid dout", dout, '0);
        rst = 1'b0;
        set_cfg(2'b10, 1'b1);
        fifo_word = WA;
        rd(1'b1, {27'b0, 9'h1A3}, "R1 first read pops");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule